// File: doc/BRIEF.md
# Multi-channel DMA control and status register bank

This block is the shared register file that sits beside a sixteen-channel descriptor DMA engine. It keeps the per-channel completion flags and their interrupt enables, the per-channel error flags together with a bit telling a bus fault apart from a termination, and the per-channel freeze and reset requests. It also holds one group of registers per channel: a next-command pointer, a buffer address, a semaphore counter and a read-only view of the channel's state machine. The data movers drive event pulses and state codes in, and take freeze, reset, semaphore-busy and burst enables out.

Software reaches every shared register and every pointer register through three addresses: the plain offset replaces the value, offset+4 ORs in the written ones and offset+8 clears the written ones. Single bits can therefore be changed without a read-modify-write. A channel reset request is held back while that channel reports its read-flush state and is released when the state changes or a bounded wait runs out. Reads are combinational from the address; writes take effect at the clock edge on which `reg_wr` is high.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, and `irq`, `freeze`, `chan_reset`, `sem_busy`, `burst_en` and `burst8_en` are all zero.
- R2: The completion register at 0x010 holds channel n's completion flag in bit n and its interrupt enable in bit 16+n. A pulse on `ev_done[n]` sets the flag on the next edge.
- R3: The error register at 0x020 holds channel n's error flag in bit n and its kind in bit 16+n (0 = termination, 1 = bus error). `ev_buserr[n]` sets flag and kind 1; `ev_term[n]` without `ev_done[n]` in the same cycle sets the flag with kind 0; a termination together with a completion sets no error.
- R4: For the registers at 0x000, 0x010, 0x020, 0x030 and each pointer and buffer register, a write at the base offset replaces the value, at +4 ORs the data in, at +8 clears the bits written as one, and at +12 changes nothing. All three aliases read the register.
- R5: An event that sets a completion or error flag wins over a software clear of that flag in the same cycle.
- R6: `irq[n]` is high exactly when channel n's completion flag and enable are both set, or its error flag is set.
- R7: Bit n of the channel control register at 0x030 drives `freeze[n]`. Bit 28 of register 0x000 drives `burst_en` and bit 29 drives `burst8_en`.
- R8: Setting bit 16+n of register 0x030 while channel n's state is not 0x8 makes `chan_reset[n]` high for exactly one cycle, starting one cycle after the bit is set; the bit then reads zero and the channel's semaphore is zero.
- R9: While channel n's state is 0x8 (read flush) a reset request stays pending with `chan_reset[n]` low; the pulse follows one cycle after the state changes. Clearing the request bit while pending cancels it.
- R10: If the state stays 0x8, the reset is applied anyway: `chan_reset[n]` rises FLUSH_TMO cycles after the request bit became visible.
- R11: Channel n's next-command pointer is at 0x110+n*0x70 and its buffer address at 0x130+n*0x70, both 32-bit read/write. Its debug register at 0x150+n*0x70 is read-only and returns `chan_state` of channel n in bits 3:0, zero above.
- R12: Channel n's semaphore at 0x140+n*0x70 adds the low 8 written bits on a write, decrements by one for each cycle `sem_dec[n]` is high while it is non-zero, and `sem_busy[n]` is high whenever it is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_done | input | 16 | Per-channel completion pulse |
| ev_term | input | 16 | Per-channel termination pulse |
| ev_buserr | input | 16 | Per-channel bus error pulse |
| chan_state | input | 64 | Per-channel 4-bit state code, channel n at bits 4n+3:4n |
| sem_dec | input | 16 | Per-channel semaphore decrement |
| irq | output | 16 | Per-channel combined interrupt |
| freeze | output | 16 | Per-channel freeze |
| chan_reset | output | 16 | Per-channel one-cycle reset pulse |
| sem_busy | output | 16 | Per-channel semaphore non-zero |
| burst_en | output | 1 | Bursts allowed |
| burst8_en | output | 1 | 8-beat bursts allowed |

## Verification
The bench sweeps every channel through all eight combinations of done, termination and bus error, so a design that flagged a termination-with-completion as an error, or mislabelled the kind bit, shows a wrong error word or a spurious `irq`. A same-cycle event and software clear targets the race where a design that let the clear win would drop an interrupt. Reset requests are driven in normal state, held in read flush and released, left to time out, and cancelled, catching designs that reset during the flush, hang forever, fire one cycle off, or ignore the cancel. Per-channel pointer, semaphore and debug addresses are checked for every channel, which exposes a wrong stride or base.

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int NCH       = 16,
  parameter int AW        = 12,
  parameter int SEMW      = 8,
  parameter int FLUSH_TMO = 1024,
  parameter int PTR_OFF   = 'h110,
  parameter int BAR_OFF   = 'h130,
  parameter int SEM_OFF   = 'h140,
  parameter int DBG_OFF   = 'h150,
  parameter int STRIDE    = 'h70,
  parameter logic [3:0] FLUSH_CODE = 4'h8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NCH-1:0]   ev_done,
  input  logic [NCH-1:0]   ev_term,
  input  logic [NCH-1:0]   ev_buserr,
  input  logic [NCH*4-1:0] chan_state,
  input  logic [NCH-1:0]   sem_dec,
  output logic [NCH-1:0]   irq,
  output logic [NCH-1:0]   freeze,
  output logic [NCH-1:0]   chan_reset,
  output logic [NCH-1:0]   sem_busy,
  output logic             burst_en,
  output logic             burst8_en
);
  localparam int TW  = $clog2(FLUSH_TMO + 1);
  localparam int BW  = AW - 4;
  localparam int HI  = 16;

  logic [NCH-1:0] cflag, cen, eflag, ekind, frz, rreq, go;
  logic           bst, bst8;
  logic [31:0]    ptr [NCH];
  logic [31:0]    bar [NCH];
  logic [SEMW-1:0] sem [NCH];
  logic [TW-1:0]  tcnt [NCH];

  wire [3:0]    al      = reg_addr[3:0];
  wire [BW-1:0] blk     = reg_addr[AW-1:4];
  wire          al_ok   = (al == 4'h0) || (al == 4'h4) || (al == 4'h8);
  wire          wr_ok   = reg_wr && al_ok;

  function automatic logic [31:0] upd(input logic [31:0] old, input logic [31:0] w, input logic [3:0] a);
    case (a)
      4'h4:    return old | w;
      4'h8:    return old & ~w;
      default: return w;
    endcase
  endfunction

  wire [31:0] r0 = {2'b00, bst8, bst, 28'h0};
  wire [31:0] r1 = (32'(cen)  << HI) | 32'(cflag);
  wire [31:0] r2 = (32'(ekind) << HI) | 32'(eflag);
  wire [31:0] r3 = (32'(rreq) << HI) | 32'(frz);

  wire hit0 = wr_ok && (blk == BW'(0));
  wire hit1 = wr_ok && (blk == BW'(1));
  wire hit2 = wr_ok && (blk == BW'(2));
  wire hit3 = wr_ok && (blk == BW'(3));

  wire [31:0] w0 = upd(r0, reg_wdata, al);
  wire [31:0] w1 = upd(r1, reg_wdata, al);
  wire [31:0] w2 = upd(r2, reg_wdata, al);
  wire [31:0] w3 = upd(r3, reg_wdata, al);

  wire [NCH-1:0] cflag_sw = hit1 ? w1[NCH-1:0]  : cflag;
  wire [NCH-1:0] cen_sw   = hit1 ? w1[HI+:NCH]  : cen;
  wire [NCH-1:0] eflag_sw = hit2 ? w2[NCH-1:0]  : eflag;
  wire [NCH-1:0] ekind_sw = hit2 ? w2[HI+:NCH]  : ekind;
  wire [NCH-1:0] frz_sw   = hit3 ? w3[NCH-1:0]  : frz;
  wire [NCH-1:0] rreq_sw  = hit3 ? w3[HI+:NCH]  : rreq;

  wire [NCH-1:0] term_err = ev_term & ~ev_done & ~ev_buserr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cflag <= '0; cen <= '0; eflag <= '0; ekind <= '0;
      frz <= '0; rreq <= '0; chan_reset <= '0;
      bst <= 1'b0; bst8 <= 1'b0;
    end else begin
      cflag      <= cflag_sw | ev_done;
      cen        <= cen_sw;
      eflag      <= eflag_sw | ev_buserr | term_err;
      ekind      <= (ekind_sw | ev_buserr) & ~term_err;
      frz        <= frz_sw;
      rreq       <= rreq_sw & ~go;
      chan_reset <= go;
      if (hit0) begin
        bst  <= w0[28];
        bst8 <= w0[29];
      end
    end
  end

  assign irq       = (cflag & cen) | eflag;
  assign freeze    = frz;
  assign burst_en  = bst;
  assign burst8_en = bst8;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [BW-1:0] PB = BW'((PTR_OFF + n * STRIDE) >> 4);
    localparam logic [BW-1:0] BB = BW'((BAR_OFF + n * STRIDE) >> 4);
    localparam logic [BW-1:0] SB = BW'((SEM_OFF + n * STRIDE) >> 4);

    wire in_flush = chan_state[4*n +: 4] == FLUSH_CODE;
    wire expired  = tcnt[n] == TW'(FLUSH_TMO - 1);
    assign go[n]  = rreq[n] && (!in_flush || expired);

    wire hit_p = wr_ok && (blk == PB);
    wire hit_b = wr_ok && (blk == BB);
    wire hit_s = reg_wr && (al == 4'h0) && (blk == SB);
    wire [SEMW-1:0] add = hit_s ? reg_wdata[SEMW-1:0] : '0;
    wire [SEMW-1:0] dec = (sem_dec[n] && sem[n] != '0) ? SEMW'(1) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr[n]  <= '0;
        bar[n]  <= '0;
        sem[n]  <= '0;
        tcnt[n] <= '0;
      end else begin
        if (hit_p) ptr[n] <= upd(ptr[n], reg_wdata, al);
        if (hit_b) bar[n] <= upd(bar[n], reg_wdata, al);
        sem[n]  <= go[n] ? '0 : sem[n] + add - dec;
        tcnt[n] <= (rreq[n] && !go[n]) ? tcnt[n] + TW'(1) : '0;
      end
    end

    assign sem_busy[n] = sem[n] != '0;

    AST_RST_NOT_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (rreq[n] && !in_flush) |=> chan_reset[n]);                         // R8
    AST_RST_CLEARS_SEM: assert property (@(posedge clk) disable iff (!rst_n)
      chan_reset[n] |-> (sem[n] == '0));                                 // R8
    AST_FLUSH_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tcnt[n] < TW'(FLUSH_TMO));                                         // R10
  end

  always_comb begin
    reg_rdata = '0;
    if (al_ok) begin
      case (blk)
        BW'(0): reg_rdata = r0;
        BW'(1): reg_rdata = r1;
        BW'(2): reg_rdata = r2;
        BW'(3): reg_rdata = r3;
        default: ;
      endcase
      for (int i = 0; i < NCH; i++) begin
        if (blk == BW'((PTR_OFF + i * STRIDE) >> 4)) reg_rdata = ptr[i];
        if (blk == BW'((BAR_OFF + i * STRIDE) >> 4)) reg_rdata = bar[i];
      end
    end
    if (al == 4'h0) begin
      for (int i = 0; i < NCH; i++) begin
        if (blk == BW'((SEM_OFF + i * STRIDE) >> 4)) reg_rdata = 32'(sem[i]);
        if (blk == BW'((DBG_OFF + i * STRIDE) >> 4)) reg_rdata = 32'(chan_state[4*i +: 4]);
      end
    end
  end

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_done) |=> ((cflag & $past(ev_done)) == $past(ev_done)));        // R2
  AST_BUSERR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_buserr) |=> ((eflag & ekind & $past(ev_buserr)) == $past(ev_buserr))); // R3
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_reset & $past(chan_reset)) == '0);                             // R8
  AST_REQ_DROPS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_reset & rreq) == '0);                                          // R8
endmodule

// File: tb/tb_dma_ctrl_regs.sv
`timescale 1ns/1ps
module tb_dma_ctrl_regs;
  localparam int NCH = 16;
  localparam int TMO = 12;

  logic clk = 0, rst_n = 0;
  logic [11:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] ev_done = '0, ev_term = '0, ev_buserr = '0, sem_dec = '0;
  logic [NCH*4-1:0] chan_state = '0;
  logic [NCH-1:0] irq, freeze, chan_reset, sem_busy;
  logic burst_en, burst8_en;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  dma_ctrl_regs #(.FLUSH_TMO(TMO)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [11:0] chaddr(input int base, input int n);
    return 12'(base + n * 'h70);
  endfunction

  initial begin
    #(200000 * 5);
    fails++; runs++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(12'(a * 16), v); check("R1", v, 0); end
    for (int n = 0; n < NCH; n++) begin rd(chaddr('h110, n), v); check("R1", v, 0); end
    check("R1", {irq, freeze}, 0);
    check("R1", {chan_reset, sem_busy, 14'b0, burst_en, burst8_en}, 0);

    // R2 R3 R6 sweep of all event combinations on every channel
    wr(12'h010, 32'hA5A5_0000);
    for (int n = 0; n < NCH; n++) begin
      for (int c = 0; c < 8; c++) begin
        logic d, t, b, e, en;
        d = c[0]; t = c[1]; b = c[2];
        e = b | (t & ~d);
        en = (16'hA5A5 >> n) & 1;
        @(negedge clk);
        ev_done[n] = d; ev_term[n] = t; ev_buserr[n] = b;
        @(negedge clk);
        ev_done = '0; ev_term = '0; ev_buserr = '0;
        rd(12'h010, v); check("R2", v, 32'hA5A5_0000 | (32'(d) << n));
        rd(12'h020, v); check("R3", v, (32'(e) << n) | (32'(b) << (16 + n)));
        check("R6", 32'(irq), 32'((d & en) | e) << n);
        wr(12'h018, 32'h0000_FFFF);
        wr(12'h028, 32'hFFFF_FFFF);
      end
    end

    // R5 event beats same-cycle software clear
    wr(12'h010, 32'h0);
    @(negedge clk);
    ev_done[3] = 1; ev_buserr[7] = 1;
    reg_addr = 12'h018; reg_wdata = 32'hFFFF; reg_wr = 1;
    @(negedge clk);
    ev_done = '0; ev_buserr = '0; reg_wr = 0;
    rd(12'h010, v); check("R5", v, 32'h0000_0008);
    wr(12'h028, 32'hFFFF_FFFF);
    @(negedge clk);
    ev_buserr[7] = 1;
    reg_addr = 12'h028; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1;
    @(negedge clk);
    ev_buserr = '0; reg_wr = 0;
    rd(12'h020, v); check("R5", v, 32'h0080_0080);
    wr(12'h028, 32'hFFFF_FFFF);

    // R4 R7 aliases on shared registers, freeze and bursts
    wr(12'h034, 32'h0000_5A5A); check("R7", 32'(freeze), 32'h5A5A);
    wr(12'h038, 32'h0000_000F); check("R7", 32'(freeze), 32'h5A50);
    wr(12'h03C, 32'h0000_FFFF); rd(12'h034, v); check("R4", v, 32'h0000_5A50);
    wr(12'h030, 32'h0000_0101); rd(12'h038, v); check("R4", v, 32'h0000_0101);
    wr(12'h004, 32'h1000_0000); check("R7", {burst8_en, burst_en}, 2'b01);
    wr(12'h004, 32'h2000_0000); rd(12'h000, v); check("R7", v, 32'h3000_0000);
    wr(12'h008, 32'h1000_0000); check("R7", {burst8_en, burst_en}, 2'b10);
    wr(12'h000, 32'h0); check("R7", {burst8_en, burst_en}, 2'b00);

    // R4 R11 per-channel pointer and buffer registers
    for (int n = 0; n < NCH; n++) begin
      logic [31:0] p;
      p = 32'h1000_0000 + n * 32'h111;
      wr(chaddr('h110, n), p);
      wr(chaddr('h110, n) + 4, 32'h0000_000F);
      wr(chaddr('h110, n) + 8, 32'h1000_0000);
      wr(chaddr('h110, n) + 12, 32'hFFFF_FFFF);
      rd(chaddr('h110, n) + 4, v); check("R4", v, (p | 32'hF) & ~32'h1000_0000);
      wr(chaddr('h130, n), ~p);
    end
    for (int n = 0; n < NCH; n++) begin
      rd(chaddr('h130, n), v); check("R11", v, ~(32'h1000_0000 + n * 32'h111));
    end
    for (int n = 0; n < NCH; n++) chan_state[4*n +: 4] = 4'((n * 7 + 3) & 15);
    for (int n = 0; n < NCH; n++) begin
      rd(chaddr('h150, n), v); check("R11", v, 32'((n * 7 + 3) & 15));
      wr(chaddr('h150, n), 32'hFFFF_FFFF);
      rd(chaddr('h150, n), v); check("R11", v, 32'((n * 7 + 3) & 15));
    end
    chan_state = '0;

    // R12 semaphore on every channel
    for (int n = 0; n < NCH; n++) begin
      wr(chaddr('h140, n), 32'h0000_0102);
      wr(chaddr('h140, n), 32'h1);
      rd(chaddr('h140, n), v); check("R12", v, 3);
      check("R12", 32'(sem_busy), 32'(1) << n);
      @(negedge clk); sem_dec[n] = 1;
      repeat (4) @(negedge clk);
      sem_dec[n] = 0;
      rd(chaddr('h140, n), v); check("R12", v, 0);
      check("R12", 32'(sem_busy), 0);
    end

    // R8 reset in normal state
    wr(chaddr('h140, 5), 32'h4);
    wr(12'h034, 32'h0020_0000);
    rd(12'h030, v); check("R8", v & 32'hFFFF_0000, 32'h0020_0000);
    check("R8", 32'(chan_reset), 0);
    @(negedge clk); check("R8", 32'(chan_reset), 32'h20);
    rd(12'h030, v); check("R8", v & 32'hFFFF_0000, 0);
    rd(chaddr('h140, 5), v); check("R8", v, 0);
    @(negedge clk); check("R8", 32'(chan_reset), 0);

    // R9 held in read flush, released on state change
    chan_state[8 +: 4] = 4'h8;
    wr(12'h034, 32'h0004_0000);
    for (int i = 0; i < 4; i++) begin @(negedge clk); check("R9", 32'(chan_reset), 0); end
    chan_state[8 +: 4] = 4'h3;
    @(negedge clk); check("R9", 32'(chan_reset), 32'h4);
    @(negedge clk); check("R9", 32'(chan_reset), 0);
    chan_state = '0;

    // R9 cancel while pending
    chan_state[36 +: 4] = 4'h8;
    wr(12'h034, 32'h0200_0000);
    wr(12'h038, 32'h0200_0000);
    for (int i = 0; i < TMO + 3; i++) begin @(negedge clk); check("R9", 32'(chan_reset), 0); end

    // R10 timeout while stuck in read flush
    wr(12'h034, 32'h0200_0000);
    for (int i = 1; i < TMO; i++) begin @(negedge clk); check("R10", 32'(chan_reset), 0); end
    @(negedge clk); check("R10", 32'(chan_reset), 32'h200);
    rd(12'h030, v); check("R10", v & 32'hFFFF_0000, 0);
    @(negedge clk); check("R10", 32'(chan_reset), 0);
    chan_state = '0;

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule